// File: doc/BRIEF.md
# H-Bridge Gate Decode with Protection

This block turns the control requests for one full bridge into four gate enables: the high-side (source) and low-side (sink) switch of leg A and of leg B. A direction bit picks which diagonal conducts. An enable bit either lets that diagonal drive or, when low, chops the bridge into a recirculation path chosen by a decay-mode bit. While the enable is high, a chopping sequencer can also call for a decay phase through a two-bit phase code. During any recirculation, a zero-current flag from the sensing front end turns every switch off. This synchronous-rectification cutoff stops the load current from reversing.

Protection acts at two levels. Over-temperature, a low regulator, low logic supply and sleep remove every gate. A low charge pump removes only the two source gates. These inputs mask the gates at once, without waiting for a clock, and the mask is lifted on a clock edge. All pattern changes go through a dead-time stage. Switches that must turn off do so on the next edge. Switches that must turn on wait for a count given at a port, so that the source and sink of a leg can never conduct at the same time.

Top module: `hbg_gate_ctrl`

## Requirements
- R1: gate_o bit order is {source A, sink A, source B, sink B}. With en_i high and phase code 0 (drive), dir_i=1 settles to 4'b1001 (leg A high, leg B low) and dir_i=0 settles to 4'b0110.
- R2: With en_i low and mode_slow_i=0, the bridge settles to the diagonal opposite the drive pair: 4'b0110 for dir_i=1 and 4'b1001 for dir_i=0.
- R3: With en_i low and mode_slow_i=1, the bridge settles to both sinks on and both sources off (4'b0101), whatever dir_i is.
- R4: With en_i high, phase code 1 gives both sinks (4'b0101), phase code 2 gives the opposite diagonal, and phase code 3 turns all gates off.
- R5: While recirculating (en_i low, or phase code not 0), zc_i high makes gate_o 4'b0000 from the next clock edge on. While driving (en_i high and phase code 0), zc_i has no effect.
- R6: ot_i, uv_i or reg_low_i high forces gate_o to 0 without waiting for a clock edge. After the last of them clears, the gates stay off until the next rising clock edge.
- R7: cp_low_i high forces both source gates (bits 3 and 1) to 0 without waiting for a clock edge, and leaves the sink gates as requested.
- R8: sleep_n_i low forces gate_o to 0 without waiting for a clock edge.
- R9: A gate that must turn off does so on the first clock edge after the request changes. A gate that must turn on does so only after dead_i+1 clock edges have passed since the last turn-off edge.
- R10: The source and sink of the same leg are never on together at gate_o.
- R11: While rst_n is low, and on leaving reset, gate_o is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Direction: 1 drives leg A high and leg B low |
| en_i | input | 1 | Drive enable; low chops into external decay |
| mode_slow_i | input | 1 | External decay mode: 1 slow (both sinks), 0 fast (opposite diagonal) |
| phase_i | input | 2 | Sequencer phase code: 0 drive, 1 slow decay, 2 fast decay, 3 all off |
| zc_i | input | 1 | Zero load current detected |
| ot_i | input | 1 | Over-temperature fault |
| uv_i | input | 1 | Logic supply undervoltage fault |
| reg_low_i | input | 1 | Gate regulator low fault |
| cp_low_i | input | 1 | Charge pump low fault (sources only) |
| sleep_n_i | input | 1 | Active-low sleep request |
| dead_i | input | DT_W | Dead-time count in clock cycles |
| gate_o | output | 4 | Gate enables {source A, sink A, source B, sink B} |

## Verification
The hardest case to reach is a turn-on that comes back while the dead-time window from an earlier turn-off is still counting. Examples are a direction flip, a fault pulse or a zero-current cutoff, each followed quickly by a new request. To get there, the random stimulus changes the control inputs every few cycles with a small dead count held per run. Faults and the zero-current flag arrive as short pulses, so later requests overlap the pending count. Directed cases flip direction under a longer dead count and sample exactly one cycle before and at the first cycle the new pair may turn on.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // gate vector bit positions: {source A, sink A, source B, sink B}
  localparam int unsigned GATE_N = 4;
  localparam int unsigned G_SRC_A = 3;
  localparam int unsigned G_SNK_A = 2;
  localparam int unsigned G_SRC_B = 1;
  localparam int unsigned G_SNK_B = 0;

  typedef logic [GATE_N-1:0] gate_t;

  typedef enum logic [1:0] {
    PH_DRIVE = 2'd0,
    PH_SLOW  = 2'd1,
    PH_FAST  = 2'd2,
    PH_OFF   = 2'd3
  } decay_ph_e;

  localparam gate_t SRC_MASK = gate_t'((1 << G_SRC_A) | (1 << G_SRC_B));

  function automatic gate_t drive_pair(input logic dir);
    gate_t g;
    g = '0;
    if (dir) begin
      g[G_SRC_A] = 1'b1;
      g[G_SNK_B] = 1'b1;
    end else begin
      g[G_SRC_B] = 1'b1;
      g[G_SNK_A] = 1'b1;
    end
    return g;
  endfunction

  function automatic gate_t opposite_pair(input logic dir);
    return drive_pair(~dir);
  endfunction

  function automatic gate_t sink_pair();
    gate_t g;
    g = '0;
    g[G_SNK_A] = 1'b1;
    g[G_SNK_B] = 1'b1;
    return g;
  endfunction

endpackage

// File: rtl/hbg_req_decode.sv
module hbg_req_decode
  import hbg_pkg::*;
(
  input  logic       dir_i,
  input  logic       en_i,
  input  logic       mode_slow_i,
  input  logic [1:0] phase_i,
  input  logic       zc_i,
  input  logic       kill_all_i,
  input  logic       kill_src_i,
  output gate_t      tgt_o,
  output logic       decaying_o
);

  decay_ph_e ph;
  gate_t     base;
  gate_t     cut;

  assign ph = decay_ph_e'(phase_i);

  // requested pattern before protection
  always_comb begin
    base       = '0;
    decaying_o = 1'b1;
    if (!en_i) begin
      base = mode_slow_i ? sink_pair() : opposite_pair(dir_i);
    end else begin
      unique case (ph)
        PH_DRIVE: begin
          base       = drive_pair(dir_i);
          decaying_o = 1'b0;
        end
        PH_SLOW:  base = sink_pair();
        PH_FAST:  base = opposite_pair(dir_i);
        default:  base = '0;
      endcase
    end
  end

  // synchronous-rectification cutoff and protection masks
  always_comb begin
    cut = base;
    if (decaying_o && zc_i) cut = '0;
    if (kill_src_i)         cut = cut & ~SRC_MASK;
    if (kill_all_i)         cut = '0;
    tgt_o = cut;
  end

endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime
  import hbg_pkg::*;
#(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  gate_t           tgt_i,
  input  logic [DT_W-1:0] dead_i,
  output gate_t           cur_o
);

  gate_t           cur_q, cur_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  gate_t           drop;
  logic            upd;

  assign drop = cur_q & ~tgt_i;

  always_comb begin
    cur_d = cur_q;
    cnt_d = cnt_q;
    if (|drop) begin
      cur_d = cur_q & tgt_i;
      cnt_d = dead_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cur_d = tgt_i;
    end
  end

  assign upd = (|drop) || (cnt_q != '0) || (cur_q != tgt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign cur_o = cur_q;

endmodule

// File: rtl/hbg_out_guard.sv
module hbg_out_guard
  import hbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  kill_all_i,
  input  logic  kill_src_i,
  input  gate_t cur_i,
  output gate_t gate_o
);

  logic hold_all_q;
  logic hold_src_q;
  logic off_all;
  logic off_src;

  // holds extend a fault to the next clock edge so release is synchronous
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_all_q <= 1'b1;
      hold_src_q <= 1'b1;
    end else begin
      hold_all_q <= kill_all_i;
      hold_src_q <= kill_src_i;
    end
  end

  assign off_all = kill_all_i | hold_all_q;
  assign off_src = kill_src_i | hold_src_q;

  for (genvar b = 0; b < GATE_N; b++) begin : g_bit
    if (SRC_MASK[b]) begin : g_src
      assign gate_o[b] = cur_i[b] & ~off_all & ~off_src;
    end else begin : g_snk
      assign gate_o[b] = cur_i[b] & ~off_all;
    end
  end

endmodule

// File: rtl/hbg_gate_ctrl.sv
module hbg_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_i,
  input  logic            en_i,
  input  logic            mode_slow_i,
  input  logic [1:0]      phase_i,
  input  logic            zc_i,
  input  logic            ot_i,
  input  logic            uv_i,
  input  logic            reg_low_i,
  input  logic            cp_low_i,
  input  logic            sleep_n_i,
  input  logic [DT_W-1:0] dead_i,
  output logic [3:0]      gate_o
);

  logic  kill_all;
  gate_t tgt;
  gate_t cur;
  gate_t gate;
  logic  decaying;

  assign kill_all = ot_i | uv_i | reg_low_i | ~sleep_n_i;

  hbg_req_decode u_dec (
    .dir_i       (dir_i),
    .en_i        (en_i),
    .mode_slow_i (mode_slow_i),
    .phase_i     (phase_i),
    .zc_i        (zc_i),
    .kill_all_i  (kill_all),
    .kill_src_i  (cp_low_i),
    .tgt_o       (tgt),
    .decaying_o  (decaying)
  );

  hbg_deadtime #(.DT_W(DT_W)) u_dt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tgt_i  (tgt),
    .dead_i (dead_i),
    .cur_o  (cur)
  );

  hbg_out_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .kill_all_i (kill_all),
    .kill_src_i (cp_low_i),
    .cur_i      (cur),
    .gate_o     (gate)
  );

  assign gate_o = gate;

endmodule

// File: rtl/hbg_gate_ctrl_chk.sv
module hbg_gate_ctrl_chk #(
  parameter int unsigned DT_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en_i,
  input logic [1:0]      phase_i,
  input logic            zc_i,
  input logic            ot_i,
  input logic            uv_i,
  input logic            reg_low_i,
  input logic            cp_low_i,
  input logic            sleep_n_i,
  input logic [DT_W-1:0] dead_i,
  input logic [3:0]      gate_o
);

  logic [3:0]    prev_q;
  logic [DT_W:0] idle_q;
  logic          fell;

  assign fell = |(prev_q & ~gate_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      idle_q <= '1;
    end else begin
      prev_q <= gate_o;
      if (fell)          idle_q <= '0;
      else if (~&idle_q) idle_q <= idle_q + 1'b1;
    end
  end

  // R10
  leg_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[3] && gate_o[2]) && !(gate_o[1] && gate_o[0]));

  // R8
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n_i |-> gate_o == 4'b0000);

  // R6
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_i || uv_i || reg_low_i) |-> gate_o == 4'b0000);

  // R7
  cp_src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_low_i |-> (gate_o[3] == 1'b0 && gate_o[1] == 1'b0));

  // R5
  zc_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zc_i && (!en_i || phase_i != 2'd0)) |=> gate_o == 4'b0000);

  // R9
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate_o & ~prev_q)) |-> idle_q >= {1'b0, dead_i});

endmodule

bind hbg_gate_ctrl hbg_gate_ctrl_chk #(.DT_W(DT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_i      (en_i),
  .phase_i   (phase_i),
  .zc_i      (zc_i),
  .ot_i      (ot_i),
  .uv_i      (uv_i),
  .reg_low_i (reg_low_i),
  .cp_low_i  (cp_low_i),
  .sleep_n_i (sleep_n_i),
  .dead_i    (dead_i),
  .gate_o    (gate_o)
);

// File: tb/test_hbg_gate_ctrl.sv
`timescale 1ns/1ps
module test_hbg_gate_ctrl;

  localparam int unsigned DT_W = 6;

  logic            clk;
  logic            rst_n;
  logic            dir_i, en_i, mode_slow_i, zc_i;
  logic [1:0]      phase_i;
  logic            ot_i, uv_i, reg_low_i, cp_low_i, sleep_n_i;
  logic [DT_W-1:0] dead_i;
  logic [3:0]      gate_o;

  int unsigned checks = 0;
  int unsigned errs   = 0;
  bit          done   = 0;

  hbg_gate_ctrl #(.DT_W(DT_W)) i_hbg_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .en_i(en_i),
    .mode_slow_i(mode_slow_i), .phase_i(phase_i), .zc_i(zc_i),
    .ot_i(ot_i), .uv_i(uv_i), .reg_low_i(reg_low_i), .cp_low_i(cp_low_i),
    .sleep_n_i(sleep_n_i), .dead_i(dead_i), .gate_o(gate_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected requested pattern, from the requirements
  function automatic logic [3:0] want(input logic d, input logic e,
                                      input logic s, input logic [1:0] p,
                                      input logic z, input logic k,
                                      input logic c);
    logic [3:0] w;
    logic       dec;
    dec = 1'b1;
    if (!e)             w = s ? 4'b0101 : (d ? 4'b0110 : 4'b1001);
    else if (p == 2'd0) begin w = d ? 4'b1001 : 4'b0110; dec = 1'b0; end
    else if (p == 2'd1) w = 4'b0101;
    else if (p == 2'd2) w = d ? 4'b0110 : 4'b1001;
    else                w = 4'b0000;
    if (dec && z) w = 4'b0000;
    if (c) w = w & 4'b0101;
    if (k) w = 4'b0000;
    return w;
  endfunction

  // bench model of the timing rules
  logic [3:0]      m_cur;
  logic [DT_W-1:0] m_wait;
  logic            m_hk, m_hc;
  logic            kill_now;
  logic [3:0]      m_tgt;

  assign kill_now = ot_i | uv_i | reg_low_i | ~sleep_n_i;
  assign m_tgt    = want(dir_i, en_i, mode_slow_i, phase_i, zc_i, kill_now, cp_low_i);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur <= 4'b0; m_wait <= '0; m_hk <= 1'b1; m_hc <= 1'b1;
    end else begin
      m_hk <= kill_now;
      m_hc <= cp_low_i;
      if (|(m_cur & ~m_tgt)) begin
        m_cur  <= m_cur & m_tgt;
        m_wait <= dead_i;
      end else if (m_wait != 0) begin
        m_wait <= m_wait - 1'b1;
      end else begin
        m_cur <= m_tgt;
      end
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] o;
    o = m_cur;
    if (kill_now || m_hk)   o = 4'b0000;
    if (cp_low_i || m_hc)   o = o & 4'b0101;
    return o;
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (gate_o !== exp) begin
      errs++;
      $display("FAIL %s: gate_o=%b expected=%b at %0t", req, gate_o, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle_inputs();
    dir_i = 1'b1; en_i = 1'b1; mode_slow_i = 1'b0; phase_i = 2'd0; zc_i = 1'b0;
    ot_i = 1'b0; uv_i = 1'b0; reg_low_i = 1'b0; cp_low_i = 1'b0; sleep_n_i = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    idle_inputs();
    dead_i = 6'd2;
    rst_n  = 1'b0;
    cyc(1);
    #1 check("R11 in reset", 4'b0000);
    cyc(2);
    rst_n = 1'b1;
    #1 check("R11 after reset", 4'b0000);
    cyc(6);
    check("R1 forward drive", 4'b1001);
    dir_i = 1'b0; cyc(8);
    check("R1 reverse drive", 4'b0110);
    zc_i = 1'b1; cyc(4);
    check("R5 zc ignored while driving", 4'b0110);
    zc_i = 1'b0;
    dir_i = 1'b1; cyc(8);
    en_i = 1'b0; mode_slow_i = 1'b0; cyc(8);
    check("R2 external fast decay dir=1", 4'b0110);
    dir_i = 1'b0; cyc(8);
    check("R2 external fast decay dir=0", 4'b1001);
    mode_slow_i = 1'b1; cyc(8);
    check("R3 external slow decay", 4'b0101);
    zc_i = 1'b1; cyc(1);
    check("R5 zc cutoff in external decay", 4'b0000);
    zc_i = 1'b0; en_i = 1'b1; dir_i = 1'b1; phase_i = 2'd1; cyc(8);
    check("R4 internal slow", 4'b0101);
    phase_i = 2'd2; cyc(8);
    check("R4 internal fast", 4'b0110);
    zc_i = 1'b1; cyc(1);
    check("R5 zc cutoff in internal decay", 4'b0000);
    zc_i = 1'b0; phase_i = 2'd3; cyc(8);
    check("R4 off phase", 4'b0000);

    // dead-time window, dead=3
    phase_i = 2'd0; dead_i = 6'd3; cyc(10);
    check("R9 settled forward", 4'b1001);
    dir_i = 1'b0; cyc(1);
    check("R9 turn-off on first edge", 4'b0000);
    cyc(3);
    check("R9 still waiting after dead edges", 4'b0000);
    cyc(1);
    check("R9 turn-on after dead+1 edges", 4'b0110);

    // asynchronous faults, synchronous release
    dead_i = 6'd0; dir_i = 1'b1; cyc(6);
    @(negedge clk); ot_i = 1'b1; #1 check("R6 thermal immediate", 4'b0000);
    @(negedge clk); ot_i = 1'b0; #1 check("R6 held until edge", 4'b0000);
    @(negedge clk); check("R6 released at edge", 4'b1001);
    uv_i = 1'b1; #1 check("R6 undervoltage immediate", 4'b0000);
    cyc(2); uv_i = 1'b0; cyc(3);
    reg_low_i = 1'b1; #1 check("R6 regulator low immediate", 4'b0000);
    cyc(2); reg_low_i = 1'b0; cyc(3);
    cp_low_i = 1'b1; #1 check("R7 charge pump immediate", 4'b0001);
    cyc(3); check("R7 sinks kept", 4'b0001);
    cp_low_i = 1'b0; cyc(3);
    sleep_n_i = 1'b0; #1 check("R8 sleep immediate", 4'b0000);
    cyc(3); sleep_n_i = 1'b1; cyc(4);
    check("R1 recovered", 4'b1001);

    // constrained random runs, one dead count per run
    for (int run = 0; run < 4; run++) begin
      sleep_n_i = 1'b0; cyc(20);
      dead_i = DT_W'($urandom_range(0, 5));
      sleep_n_i = 1'b1;
      for (int k = 0; k < 600; k++) begin
        if ($urandom_range(0, 3) == 0) dir_i = 1'($urandom);
        if ($urandom_range(0, 3) == 0) en_i = 1'($urandom);
        if ($urandom_range(0, 5) == 0) mode_slow_i = 1'($urandom);
        if ($urandom_range(0, 4) == 0) phase_i = 2'($urandom);
        zc_i      = ($urandom_range(0, 5) == 0);
        ot_i      = ($urandom_range(0, 40) == 0);
        uv_i      = ($urandom_range(0, 40) == 0);
        reg_low_i = ($urandom_range(0, 40) == 0);
        cp_low_i  = ($urandom_range(0, 25) == 0);
        sleep_n_i = ($urandom_range(0, 50) != 0);
        #1 check("R9 random model", model_out());
        if ((gate_o[3] & gate_o[2]) | (gate_o[1] & gate_o[0])) begin
          checks++; errs++;
          $display("FAIL R10: gate_o=%b expected=no leg with both on", gate_o);
        end
        cyc(1);
        check("R9 random model after edge", model_out());
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule